// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block holds the processor's current privilege level (kernel or user) and its interrupt-enable flag, and decides each cycle whether control must leave the running instruction stream. It accepts synchronous exception requests, system calls, translation misses, external interrupt lines and privileged-instruction hints from decode. When it takes an event, it records why the event happened and where to resume. It then forces kernel mode with interrupts off and signals a redirect to one of two entry addresses. A return strobe issued from kernel mode reverses this in a single cycle.

The saved state consists of the resume PC, the event cause, a two-deep mode/enable stack and the last faulting address. Kernel code reads and writes it through a small register port. The redirect output is a one-cycle pulse with no back-pressure: the fetch unit must act on `redir_valid` in the cycle it is high. The block has no valid/ready stream interfaces. Every pin is a plain control or status level, or a strobe that is sampled on the rising clock edge.

Top module: `priv_trap_ctrl`

## Requirements
- R1: Reset leaves kernel mode (`mode_o`=1) with interrupts off (`ie_o`=0), a status value of 4'b1010, and zero in the resume-PC, cause and bad-address registers. In the first cycle after reset `redir_valid`=1 with `redir_pc`=RESET_VEC.
- R2: A taken translation miss redirects to TLB_VEC. Every other taken trap redirects to GEN_VEC. `redir_valid` is high only in the cycle that follows the clock edge that accepted a trap or return.
- R3: The cause register is {kind[1:0], code[CODE_W-1:0]}, with kind 0 for an interrupt, 1 for an exception and 2 for a system call. Codes are 2 for a translation miss, 10 for a privilege violation, 8 for a system call, `exc_code` for a requested exception, and the lowest-numbered pending line for an interrupt.
- R4: On a taken trap, the resume-PC register captures `cur_pc` from the accepting cycle.
- R5: The status register holds bit0 current IE, bit1 current mode, bit2 previous IE and bit3 previous mode. On a taken trap, the current pair moves into the previous pair and the current pair becomes kernel with IE=0.
- R6: A translation miss, or an exception request with `exc_mem`=1, captures `bad_va`. Its page number reads back as `bad_va` shifted right by PAGE_BITS. All other events leave the bad address unchanged.
- R7: `priv_instr` in user mode raises a privilege-violation exception. In kernel mode it raises nothing.
- R8: `eret` in kernel mode copies the previous pair into the current pair and redirects to the resume-PC register one cycle later. `eret` in user mode is a privilege violation.
- R9: An interrupt line is taken only while IE=1. While IE=0, pending lines cause no redirect.
- R10: Only one event is accepted per cycle. The priority order is translation miss, requested exception, privilege violation, system call, interrupt, return.
- R11: `csr_sel` picks 0 resume PC, 1 cause, 2 status, 3 bad address, or 4 page number (read-only). In kernel mode, reads return the register combinationally and writes take effect at the next edge. A user-mode access returns 0, writes nothing and is a privilege violation.
- R12: A register write in a cycle that also accepts a trap or a return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlb_miss | input | 1 | Translation miss for the current access |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | CODE_W | Code for `exc_req` |
| exc_mem | input | 1 | `exc_req` is a memory fault |
| sys_req | input | 1 | System call |
| irq_req | input | IRQ_N | External interrupt lines |
| priv_instr | input | 1 | Decode flags a privileged instruction |
| eret | input | 1 | Return-from-exception strobe |
| cur_pc | input | XLEN | PC of the current instruction |
| bad_va | input | XLEN | Faulting virtual address |
| csr_req | input | 1 | Saved-state register access |
| csr_we | input | 1 | Access is a write |
| csr_sel | input | 3 | Register select |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data |
| mode_o | output | 1 | 1 = kernel, 0 = user |
| ie_o | output | 1 | Interrupt enable |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | XLEN | Redirect target |

## Verification
The bench builds the block with XLEN=32, IRQ_N=4, CODE_W=4 and PAGE_BITS=8. It uses distinct reset, miss and general vectors, so a wrong target selection shows up directly on `redir_pc`. Four interrupt lines allow several lines to be pending at once, which exercises the lowest-index pick. The small page size makes the shifted page-number readback differ visibly from the raw address. Directed priority collisions and mode round trips come first, followed by a long random run in which status writes keep moving the block between user and kernel mode.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

  typedef enum logic [1:0] {
    KIND_INT = 2'd0,
    KIND_EXC = 2'd1,
    KIND_SYS = 2'd2
  } ev_kind_e;

  localparam int CODE_TLB  = 2;
  localparam int CODE_SYS  = 8;
  localparam int CODE_PRIV = 10;

  localparam logic [2:0] SEL_EPC    = 3'd0;
  localparam logic [2:0] SEL_CAUSE  = 3'd1;
  localparam logic [2:0] SEL_STATUS = 3'd2;
  localparam logic [2:0] SEL_BADVA  = 3'd3;
  localparam logic [2:0] SEL_BADVPN = 3'd4;

  localparam int G_TLB  = 0;
  localparam int G_EXC  = 1;
  localparam int G_PRIV = 2;
  localparam int G_SYS  = 3;
  localparam int G_IRQ  = 4;
  localparam int G_RET  = 5;
  localparam int GRANT_W = 6;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import priv_trap_pkg::*;
#(
  parameter int unsigned IRQ_N  = 4,
  parameter int unsigned CODE_W = 4
) (
  input  logic               tlb_miss,
  input  logic               exc_req,
  input  logic               priv_viol,
  input  logic               sys_req,
  input  logic [IRQ_N-1:0]   irq_req,
  input  logic               ie,
  input  logic               ret_ok,
  output logic [GRANT_W-1:0] grant,
  output logic [CODE_W-1:0]  irq_idx
);

  logic irq_hit;

  assign irq_hit = ie && (|irq_req);

  // fixed priority chain, one grant at most
  always_comb begin
    grant = '0;
    if (tlb_miss)       grant[G_TLB]  = 1'b1;
    else if (exc_req)   grant[G_EXC]  = 1'b1;
    else if (priv_viol) grant[G_PRIV] = 1'b1;
    else if (sys_req)   grant[G_SYS]  = 1'b1;
    else if (irq_hit)   grant[G_IRQ]  = 1'b1;
    else if (ret_ok)    grant[G_RET]  = 1'b1;
  end

  // lowest-numbered pending line wins
  always_comb begin
    irq_idx = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (irq_req[i]) irq_idx = CODE_W'(i);
    end
  end

endmodule

// File: rtl/priv_status.sv
module priv_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter,
  input  logic       leave,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic       mode_cur,
  output logic       ie_cur,
  output logic [3:0] status
);

  logic mode_prev, ie_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cur  <= 1'b1;
      ie_cur    <= 1'b0;
      mode_prev <= 1'b1;
      ie_prev   <= 1'b0;
    end else if (enter) begin
      mode_prev <= mode_cur;
      ie_prev   <= ie_cur;
      mode_cur  <= 1'b1;
      ie_cur    <= 1'b0;
    end else if (leave) begin
      mode_cur  <= mode_prev;
      ie_cur    <= ie_prev;
    end else if (wr_en) begin
      ie_cur    <= wr_data[0];
      mode_cur  <= wr_data[1];
      ie_prev   <= wr_data[2];
      mode_prev <= wr_data[3];
    end
  end

  assign status = {mode_prev, ie_prev, mode_cur, ie_cur};

endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 4,
  localparam int unsigned CAUSE_W = 2 + CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enter,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [XLEN-1:0]    pc_in,
  input  logic               cap_bad,
  input  logic [XLEN-1:0]    bad_in,
  input  logic               wr_epc,
  input  logic               wr_cause,
  input  logic               wr_badva,
  input  logic [XLEN-1:0]    wr_data,
  output logic [XLEN-1:0]    epc,
  output logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    badva
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
    end else if (enter) begin
      epc   <= pc_in;
      cause <= cause_in;
    end else begin
      if (wr_epc)   epc   <= wr_data;
      if (wr_cause) cause <= wr_data[CAUSE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                badva <= '0;
    else if (enter && cap_bad) badva <= bad_in;
    else if (!enter && wr_badva) badva <= wr_data;
  end

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned IRQ_N     = 4,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned PAGE_BITS = 12,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0100,
  parameter logic [XLEN-1:0] TLB_VEC   = 32'h0000_0080,
  parameter logic [XLEN-1:0] GEN_VEC   = 32'h0000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tlb_miss,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_mem,
  input  logic              sys_req,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic              priv_instr,
  input  logic              eret,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   bad_va,
  input  logic              csr_req,
  input  logic              csr_we,
  input  logic [2:0]        csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              mode_o,
  output logic              ie_o,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc
);

  localparam int unsigned CAUSE_W = 2 + CODE_W;

  logic [GRANT_W-1:0] grant;
  logic [CODE_W-1:0]  irq_idx;
  logic               priv_viol, ret_ok, enter, leave, any_take;
  logic               csr_wr;
  logic [3:0]         status;
  logic [CAUSE_W-1:0] cause_in, cause_q;
  logic [XLEN-1:0]    epc_q, badva_q;
  logic               cap_bad;
  logic               redir_valid_q;
  logic [XLEN-1:0]    redir_pc_q;

  assign priv_viol = !mode_o && (priv_instr || eret || csr_req);
  assign ret_ok    = mode_o && eret;

  trap_arbiter #(.IRQ_N(IRQ_N), .CODE_W(CODE_W)) arb_i (
    .tlb_miss (tlb_miss),
    .exc_req  (exc_req),
    .priv_viol(priv_viol),
    .sys_req  (sys_req),
    .irq_req  (irq_req),
    .ie       (ie_o),
    .ret_ok   (ret_ok),
    .grant    (grant),
    .irq_idx  (irq_idx)
  );

  assign enter    = |grant[G_IRQ:G_TLB];
  assign leave    = grant[G_RET];
  assign any_take = enter || leave;
  assign csr_wr   = csr_req && csr_we && mode_o && !any_take;
  assign cap_bad  = grant[G_TLB] || (grant[G_EXC] && exc_mem);

  always_comb begin
    cause_in = '0;
    unique case (1'b1)
      grant[G_TLB]:  cause_in = {KIND_EXC, CODE_W'(CODE_TLB)};
      grant[G_EXC]:  cause_in = {KIND_EXC, exc_code};
      grant[G_PRIV]: cause_in = {KIND_EXC, CODE_W'(CODE_PRIV)};
      grant[G_SYS]:  cause_in = {KIND_SYS, CODE_W'(CODE_SYS)};
      grant[G_IRQ]:  cause_in = {KIND_INT, irq_idx};
      default:       cause_in = '0;
    endcase
  end

  priv_status stat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter   (enter),
    .leave   (leave),
    .wr_en   (csr_wr && (csr_sel == SEL_STATUS)),
    .wr_data (csr_wdata[3:0]),
    .mode_cur(mode_o),
    .ie_cur  (ie_o),
    .status  (status)
  );

  trap_state_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter   (enter),
    .cause_in(cause_in),
    .pc_in   (cur_pc),
    .cap_bad (cap_bad),
    .bad_in  (bad_va),
    .wr_epc  (csr_wr && (csr_sel == SEL_EPC)),
    .wr_cause(csr_wr && (csr_sel == SEL_CAUSE)),
    .wr_badva(csr_wr && (csr_sel == SEL_BADVA)),
    .wr_data (csr_wdata),
    .epc     (epc_q),
    .cause   (cause_q),
    .badva   (badva_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid_q <= 1'b1;
      redir_pc_q    <= RESET_VEC;
    end else begin
      redir_valid_q <= any_take;
      if (enter)      redir_pc_q <= grant[G_TLB] ? TLB_VEC : GEN_VEC;
      else if (leave) redir_pc_q <= epc_q;
    end
  end

  assign redir_valid = redir_valid_q;
  assign redir_pc    = redir_pc_q;

  always_comb begin
    csr_rdata = '0;
    if (csr_req && mode_o) begin
      case (csr_sel)
        SEL_EPC:    csr_rdata = epc_q;
        SEL_CAUSE:  csr_rdata = XLEN'(cause_q);
        SEL_STATUS: csr_rdata = XLEN'(status);
        SEL_BADVA:  csr_rdata = badva_q;
        SEL_BADVPN: csr_rdata = badva_q >> PAGE_BITS;
        default:    csr_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/priv_trap_chk.sv
module priv_trap_chk
  import priv_trap_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IRQ_N = 4,
  parameter logic [XLEN-1:0] TLB_VEC = 32'h0000_0080,
  parameter logic [XLEN-1:0] GEN_VEC = 32'h0000_0180
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tlb_miss,
  input logic               exc_req,
  input logic               sys_req,
  input logic               priv_instr,
  input logic               eret,
  input logic               csr_req,
  input logic [IRQ_N-1:0]   irq_req,
  input logic [XLEN-1:0]    cur_pc,
  input logic               mode_o,
  input logic               ie_o,
  input logic               redir_valid,
  input logic [XLEN-1:0]    redir_pc,
  input logic [XLEN-1:0]    epc,
  input logic [GRANT_W-1:0] grant
);

  // R2
  tlb_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_miss |=> redir_valid && (redir_pc == TLB_VEC));

  // R4
  epc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_miss |=> (epc == $past(cur_pc)));

  // R5
  entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant[G_IRQ:G_TLB]) |=> mode_o && !ie_o);

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_o && !tlb_miss && !exc_req && !sys_req && !eret && !priv_instr && !csr_req)
      |=> !redir_valid);

  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7
  user_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_instr && !mode_o && !tlb_miss) |=> mode_o && redir_valid && (redir_pc == GEN_VEC));

  // R8
  eret_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && mode_o && !tlb_miss && !exc_req && !sys_req && !(ie_o && (|irq_req)))
      |=> redir_valid && (redir_pc == $past(epc)));

endmodule

bind priv_trap_ctrl priv_trap_chk #(
  .XLEN(XLEN), .IRQ_N(IRQ_N), .TLB_VEC(TLB_VEC), .GEN_VEC(GEN_VEC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tlb_miss   (tlb_miss),
  .exc_req    (exc_req),
  .sys_req    (sys_req),
  .priv_instr (priv_instr),
  .eret       (eret),
  .csr_req    (csr_req),
  .irq_req    (irq_req),
  .cur_pc     (cur_pc),
  .mode_o     (mode_o),
  .ie_o       (ie_o),
  .redir_valid(redir_valid),
  .redir_pc   (redir_pc),
  .epc        (epc_q),
  .grant      (grant)
);

// File: tb/priv_trap_ctrl_tb.sv
module priv_trap_ctrl_tb_top;

  localparam int XLEN = 32;
  localparam int IRQ_N = 4;
  localparam int CODE_W = 4;
  localparam int PAGE_BITS = 8;
  localparam logic [31:0] V_RESET = 32'h0000_0100;
  localparam logic [31:0] V_TLB   = 32'h0000_0080;
  localparam logic [31:0] V_GEN   = 32'h0000_0180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tlb_miss, exc_req, exc_mem, sys_req, priv_instr, eret, csr_req, csr_we;
  logic [CODE_W-1:0] exc_code;
  logic [IRQ_N-1:0]  irq_req;
  logic [XLEN-1:0]   cur_pc, bad_va, csr_wdata, csr_rdata, redir_pc;
  logic [2:0]        csr_sel;
  logic              mode_o, ie_o, redir_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_en = 1'b0;
  string req_tag = "R1";

  always #10 clk = ~clk;

  priv_trap_ctrl #(
    .XLEN(XLEN), .IRQ_N(IRQ_N), .CODE_W(CODE_W), .PAGE_BITS(PAGE_BITS),
    .RESET_VEC(V_RESET), .TLB_VEC(V_TLB), .GEN_VEC(V_GEN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tlb_miss(tlb_miss), .exc_req(exc_req),
    .exc_code(exc_code), .exc_mem(exc_mem), .sys_req(sys_req), .irq_req(irq_req),
    .priv_instr(priv_instr), .eret(eret), .cur_pc(cur_pc), .bad_va(bad_va),
    .csr_req(csr_req), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .mode_o(mode_o), .ie_o(ie_o),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  // behavioural reference state
  bit m_mode, m_ie, m_pmode, m_pie, m_rv;
  logic [31:0] m_epc, m_badva, m_rpc;
  logic [5:0]  m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 1; m_ie = 0; m_pmode = 1; m_pie = 0;
      m_epc = 0; m_badva = 0; m_cause = 0; m_rv = 1; m_rpc = V_RESET;
    end else begin
      bit trap, viol, bad;
      int kind, code;
      logic [31:0] vec;
      trap = 1; bad = 0; kind = 1; code = 0; vec = V_GEN;
      viol = !m_mode && (priv_instr || eret || csr_req);
      if (tlb_miss) begin code = 2; vec = V_TLB; bad = 1; end
      else if (exc_req) begin code = int'(exc_code); bad = exc_mem; end
      else if (viol) code = 10;
      else if (sys_req) begin kind = 2; code = 8; end
      else if (m_ie && irq_req != 0) begin
        kind = 0;
        code = 0;
        while (!irq_req[code]) code++;
      end else trap = 0;
      if (trap) begin
        m_epc = cur_pc; m_cause = 6'(kind * 16 + code);
        if (bad) m_badva = bad_va;
        m_pmode = m_mode; m_pie = m_ie; m_mode = 1; m_ie = 0;
        m_rv = 1; m_rpc = vec;
      end else if (eret && m_mode) begin
        m_mode = m_pmode; m_ie = m_pie; m_rv = 1; m_rpc = m_epc;
      end else begin
        m_rv = 0;
        if (csr_req && csr_we && m_mode) begin
          case (csr_sel)
            3'd0: m_epc = csr_wdata;
            3'd1: m_cause = csr_wdata[5:0];
            3'd2: begin
              m_ie = csr_wdata[0]; m_mode = csr_wdata[1];
              m_pie = csr_wdata[2]; m_pmode = csr_wdata[3];
            end
            3'd3: m_badva = csr_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    if (!(csr_req && m_mode)) return 32'h0;
    case (csr_sel)
      3'd0: return m_epc;
      3'd1: return {26'h0, m_cause};
      3'd2: return {28'h0, m_pmode, m_pie, m_mode, m_ie};
      3'd3: return m_badva;
      3'd4: return m_badva / (32'h1 << PAGE_BITS);
      default: return 32'h0;
    endcase
  endfunction

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (chk_en) begin
      cmp("mode", {31'h0, mode_o}, {31'h0, m_mode});
      cmp("ie", {31'h0, ie_o}, {31'h0, m_ie});
      cmp("redir_valid", {31'h0, redir_valid}, {31'h0, m_rv});
      cmp("redir_pc", redir_pc, m_rpc);
      cmp("csr_rdata", csr_rdata, exp_rdata());
    end
  end

  task automatic idle();
    tlb_miss = 0; exc_req = 0; exc_code = 0; exc_mem = 0; sys_req = 0;
    irq_req = 0; priv_instr = 0; eret = 0; csr_req = 0; csr_we = 0;
    csr_sel = 0; csr_wdata = 0;
    cur_pc = 32'h0000_4000 + 32'($time / 20) * 4;
    bad_va = 32'hBEEF_0000 ^ cur_pc;
  endtask

  task automatic step(string tag);
    @(negedge clk);
    idle();
    req_tag = tag;
  endtask

  task automatic rd(string tag, logic [2:0] sel);
    step(tag); csr_req = 1; csr_sel = sel;
  endtask

  task automatic wr(string tag, logic [2:0] sel, logic [31:0] d);
    step(tag); csr_req = 1; csr_we = 1; csr_sel = sel; csr_wdata = d;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state and reset redirect in the first cycle out of reset
    rst_n = 1; chk_en = 1; req_tag = "R1"; csr_req = 1; csr_sel = 3'd2;
    rd("R1", 3'd0); rd("R1", 3'd1); rd("R1", 3'd3);
    // R11: kernel writes, then R8 return to user with IE set
    wr("R11", 3'd0, 32'h0000_1000);
    rd("R11", 3'd0);
    wr("R11", 3'd2, 32'h0000_0006);
    rd("R11", 3'd2);
    step("R8"); eret = 1;
    step("R8");
    // R7: privileged instruction in user mode; R5 stack push
    step("R7"); priv_instr = 1;
    rd("R5", 3'd2); rd("R3", 3'd1); rd("R4", 3'd0);
    step("R7"); priv_instr = 1;
    step("R8"); eret = 1;
    // R11: user access traps and reads zero
    step("R11"); csr_req = 1; csr_we = 1; csr_sel = 3'd0; csr_wdata = 32'hDEAD;
    rd("R11", 3'd0);
    wr("R11", 3'd2, 32'h0000_0006);
    step("R8"); eret = 1;
    // R9/R3: interrupt in user, lowest pending line
    step("R9"); irq_req = 4'b0110;
    rd("R3", 3'd1);
    // R9: masked in kernel with IE=0
    step("R9"); irq_req = 4'b1111;
    step("R9"); irq_req = 4'b1000;
    // R6: translation miss captures address and page
    step("R6"); tlb_miss = 1;
    rd("R6", 3'd3); rd("R6", 3'd4); rd("R3", 3'd1);
    // R6: non-memory exception leaves bad address
    step("R6"); exc_req = 1; exc_code = 4'd5;
    rd("R6", 3'd3);
    step("R6"); exc_req = 1; exc_code = 4'd4; exc_mem = 1;
    rd("R6", 3'd3);
    // R3: system call
    step("R3"); sys_req = 1;
    rd("R3", 3'd1);
    // R10: priority collisions
    wr("R10", 3'd2, 32'h0000_0007);
    step("R10"); tlb_miss = 1; exc_req = 1; sys_req = 1; irq_req = 4'b0001; eret = 1;
    rd("R10", 3'd1);
    step("R10"); exc_req = 1; exc_code = 4'd3; sys_req = 1;
    rd("R10", 3'd1);
    wr("R10", 3'd2, 32'h0000_0005);
    step("R10"); sys_req = 1; irq_req = 4'b0100;
    rd("R10", 3'd1);
    // R12: write dropped with return or trap in same cycle
    wr("R12", 3'd0, 32'h0000_2000);
    step("R12"); eret = 1; csr_req = 1; csr_we = 1; csr_sel = 3'd0; csr_wdata = 32'h3333;
    step("R12"); sys_req = 1; csr_req = 1; csr_we = 1; csr_sel = 3'd3; csr_wdata = 32'h4444;
    rd("R12", 3'd0); rd("R12", 3'd3);
    // R2: redirect pulse only one cycle
    step("R2"); step("R2");
    // random phase covering all requirements
    for (int k = 0; k < 3000; k++) begin
      step("R10");
      tlb_miss   = ($urandom % 16) == 0;
      exc_req    = ($urandom % 14) == 0;
      exc_code   = CODE_W'($urandom);
      exc_mem    = $urandom % 2;
      sys_req    = ($urandom % 12) == 0;
      irq_req    = (($urandom % 4) == 0) ? IRQ_N'($urandom) : '0;
      priv_instr = ($urandom % 10) == 0;
      eret       = ($urandom % 6) == 0;
      csr_req    = ($urandom % 3) == 0;
      csr_we     = $urandom % 2;
      csr_sel    = 3'($urandom % 6);
      csr_wdata  = $urandom;
      cur_pc     = $urandom;
      bad_va     = $urandom;
    end
    step("R2");
    @(negedge clk); #5;
    summary();
  end

endmodule